// File: doc/BRIEF.md
# SDRAM command decoder and mode register

This block is the command front end of a device-side SDRAM model. On every rising clock edge it samples the chip select, the three strobes (row, column, write enable), the clock enable, the bank pins and the address pins. It sorts the cycle into exactly one command and registers the result. Along with the command it presents the bank and the row or column address that go with it. For reads and writes it also gives the auto-precharge flag, and for precharge it gives the all-banks flag. Logic further down, such as the bank and burst machinery, consumes these registered values one cycle after the edge that sampled the pins.

A mode-register-set command loads the operating mode. The block holds the read latency, the burst length code, the burst order and the write mode, and it derives from them the effective burst length code for writes. Mode codes that are reserved are refused. So is any command that arrives too soon after a mode-register set. A refused cycle shows up as a no-operation, leaves the mode unchanged and sets a sticky error flag.

The mode-register gap is tracked by a small state machine with two states. `ST_READY` means commands are accepted. An accepted mode-register set moves it to `ST_MRD_WAIT`, where a counter loaded with `MRD_CYCLES-1` counts the blocked edges down. When the counter reaches 1, the machine returns to `ST_READY`. A mode-register set that is refused does not start the gap.

Top module: `sdcmd_frontend`

## Requirements
- R1: After reset the outputs are: `cmd_o` = 0 (deselect), CAS latency 3, burst length code 0, sequential order, burst writes (`wr_single_o`=0), `wr_len_o`=0 and `err_o`=0.
- R2: With `cs_n` low, the pins sampled at an edge appear as `cmd_o` right after that edge. The strobes {ras_n,cas_n,we_n} decode as follows: 000 = mode set (code 2), 111 = no-operation (1), 011 = activate (3), 101 = read (4), 100 = write (5), 010 = precharge (6), 110 = burst stop (7), 001 = refresh (R6).
- R3: With `cs_n` high the command is deselect (0) whatever the strobes are, and the mode is not changed.
- R4: An activate presents `ba` and the 12-bit row `a[11:0]`. A read or write presents `ba`, the column `a[8:0]` with the upper address bits zero, and `auto_pre_o` = `a[10]`. Other commands present address 0 and `auto_pre_o` = 0.
- R5: A precharge presents `ba` and sets `all_banks_o` = `a[10]`. `all_banks_o` is 0 for every other command.
- R6: The refresh encoding decodes as auto refresh (8) when the previous and the current sample of `cke` are both high. It decodes as self-refresh entry (9) when the previous sample is high and the current one is low. Whenever the previous sample of `cke` is low, the cycle decodes as no-operation (1).
- R7: An accepted mode set loads the mode fields from the address. CAS latency comes from `a[6:4]`, with 010 giving 2 and 011 giving 3. The burst length code is `a[2:0]`, where 0, 1, 2, 3 and 7 mean 1, 2, 4, 8 and full page. The burst order is `a[3]`, with 1 meaning interleave. Single write is `a[9]`. Outside a mode set the mode outputs do not change.
- R8: A mode set with a CAS latency code other than 010 or 011 is refused. `cmd_o` shows no-operation, the mode keeps its old value, `err_o` goes to 1, and no gap is started, so a command at the next edge is accepted.
- R9: A mode set with burst length code 100, 101 or 110, or with code 111 (full page) together with `a[3]`=1, is refused in the same way as in R8.
- R10: At the one edge that follows an accepted mode set (`MRD_CYCLES`=2), any command other than deselect or no-operation is refused. This includes another mode set. `cmd_o` shows no-operation and `err_o` is set. A command two edges after the mode set is accepted.
- R11: `err_o` stays at 1 until reset.
- R12: `wr_len_o` is 0 (one beat) while single write is selected. Otherwise it equals `burst_len_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pins sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| ba | input | 2 | Bank address |
| a | input | 12 | Address pins (row, column, flags, mode field) |
| cmd_o | output | 4 | Decoded command code (R2) |
| bank_o | output | 2 | Bank of the command |
| addr_o | output | 12 | Row or zero-extended column address |
| auto_pre_o | output | 1 | Auto-precharge with read/write |
| all_banks_o | output | 1 | Precharge applies to all banks |
| cas_lat_o | output | 2 | CAS latency, 2 or 3 |
| burst_len_o | output | 3 | Burst length code |
| burst_il_o | output | 1 | 1 = interleaved burst order |
| wr_single_o | output | 1 | 1 = writes are single beat |
| wr_len_o | output | 3 | Effective write burst length code |
| err_o | output | 1 | Sticky refusal flag |

## Verification
Two situations are hard to reach from the ports because they depend on the edge just before. The first is a command that falls inside the mode-set gap. The bench issues the mode set and then the offending command at the very next edge, and it checks both the refusal and the acceptance one edge later. It also checks that a mode set refused for a reserved code opens no gap. The second is self-refresh entry, which needs `cke` to fall in the same cycle as the refresh strobes. The bench follows it with cycles where the previous `cke` sample is low, to show that those cycles decode as no-operation.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_MRS   = 4'd2,
        CMD_ACT   = 4'd3,
        CMD_RD    = 4'd4,
        CMD_WR    = 4'd5,
        CMD_PRE   = 4'd6,
        CMD_BST   = 4'd7,
        CMD_AREF  = 4'd8,
        CMD_SREF  = 4'd9
    } cmd_e;

    typedef struct packed {
        logic [1:0] cl;
        logic [2:0] bl;
        logic       il;
        logic       wr_single;
    } mode_t;

    localparam logic [2:0] BL_FULL_PAGE = 3'b111;
    localparam logic [2:0] CL_CODE_2    = 3'b010;
    localparam logic [2:0] CL_CODE_3    = 3'b011;

    localparam mode_t MODE_AT_RESET = '{cl: 2'd3, bl: 3'd0, il: 1'b0, wr_single: 1'b0};

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
    import sdcmd_pkg::*;
(
    input  logic cke_prev,
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        cmd = CMD_NOP;
        if (!cke_prev) begin
            cmd = CMD_NOP;
        end else if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b000: cmd = CMD_MRS;
                3'b111: cmd = CMD_NOP;
                3'b011: cmd = CMD_ACT;
                3'b101: cmd = CMD_RD;
                3'b100: cmd = CMD_WR;
                3'b010: cmd = CMD_PRE;
                3'b110: cmd = CMD_BST;
                3'b001: cmd = cke ? CMD_AREF : CMD_SREF;
            endcase
        end
    end

endmodule

// File: rtl/sdcmd_mode_reg.sv
module sdcmd_mode_reg
    import sdcmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [6:0] lo_field,
    input  logic       wm_bit,
    input  logic       load,
    output logic       code_ok,
    output mode_t      mode
);

    logic [2:0] cl_code;
    logic [2:0] bl_code;
    logic       il_bit;
    logic       cl_ok;
    logic       bl_ok;

    assign cl_code = lo_field[6:4];
    assign il_bit  = lo_field[3];
    assign bl_code = lo_field[2:0];

    always_comb begin
        cl_ok   = (cl_code == CL_CODE_2) || (cl_code == CL_CODE_3);
        bl_ok   = (bl_code[2] == 1'b0) || ((bl_code == BL_FULL_PAGE) && !il_bit);
        code_ok = cl_ok && bl_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= MODE_AT_RESET;
        end else if (load) begin
            mode.cl        <= (cl_code == CL_CODE_3) ? 2'd3 : 2'd2;
            mode.bl        <= bl_code;
            mode.il        <= il_bit;
            mode.wr_single <= wm_bit;
        end
    end

    assert_load_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> code_ok)
        else $error("mode loaded from a reserved code");

    assert_mode_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode.cl == 2'd2) || (mode.cl == 2'd3)) && (mode.bl[2] == 1'b0 ||
         (mode.bl == BL_FULL_PAGE && !mode.il)))
        else $error("held mode is a reserved combination");

endmodule

// File: rtl/sdcmd_gap_fsm.sv
module sdcmd_gap_fsm #(
    parameter int MRD_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mrs_taken,
    output logic busy
);

    localparam bit HAS_GAP = (MRD_CYCLES > 1);
    localparam int CNT_W   = (MRD_CYCLES > 2) ? $clog2(MRD_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HAS_GAP ? MRD_CYCLES - 1 : 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    typedef enum logic {
        ST_READY,
        ST_MRD_WAIT
    } gap_state_e;

    gap_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_READY: begin
                if (mrs_taken && HAS_GAP) begin
                    state_d = ST_MRD_WAIT;
                    cnt_d   = CNT_LOAD;
                end
            end
            ST_MRD_WAIT: begin
                cnt_d = cnt_q - CNT_LAST;
                if (cnt_q == CNT_LAST) begin
                    state_d = ST_READY;
                end
            end
        endcase
    end

    always_comb begin
        busy = (state_q == ST_MRD_WAIT);
    end

    assert_wait_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MRD_WAIT) |-> (cnt_q != '0))
        else $error("gap counter empty while waiting");

    assert_no_mrs_in_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !mrs_taken)
        else $error("mode set taken inside the gap");

endmodule

// File: rtl/sdcmd_frontend.sv
module sdcmd_frontend
    import sdcmd_pkg::*;
#(
    parameter int ROW_W      = 12,
    parameter int COL_W      = 9,
    parameter int BANK_W     = 2,
    parameter int MRD_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] ba,
    input  logic [ROW_W-1:0]  a,
    output logic [3:0]        cmd_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ROW_W-1:0]  addr_o,
    output logic              auto_pre_o,
    output logic              all_banks_o,
    output logic [1:0]        cas_lat_o,
    output logic [2:0]        burst_len_o,
    output logic              burst_il_o,
    output logic              wr_single_o,
    output logic [2:0]        wr_len_o,
    output logic              err_o
);

    localparam int AP_BIT = 10;
    localparam int WM_BIT = 9;

    logic  cke_prev_q;
    cmd_e  raw_cmd;
    logic  gap_busy;
    logic  code_ok;
    logic  is_idle;
    logic  in_gap_reject;
    logic  bad_mode_reject;
    logic  reject;
    logic  mrs_take;
    mode_t mode;
    cmd_e  cmd_q;

    sdcmd_decode u_decode (
        .cke_prev (cke_prev_q),
        .cke      (cke),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .cmd      (raw_cmd)
    );

    always_comb begin
        is_idle         = (raw_cmd == CMD_DESEL) || (raw_cmd == CMD_NOP);
        in_gap_reject   = gap_busy && !is_idle;
        bad_mode_reject = (raw_cmd == CMD_MRS) && !code_ok && !gap_busy;
        reject          = in_gap_reject || bad_mode_reject;
        mrs_take        = (raw_cmd == CMD_MRS) && !reject;
    end

    sdcmd_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .lo_field (a[6:0]),
        .wm_bit   (a[WM_BIT]),
        .load     (mrs_take),
        .code_ok  (code_ok),
        .mode     (mode)
    );

    sdcmd_gap_fsm #(
        .MRD_CYCLES (MRD_CYCLES)
    ) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .mrs_taken (mrs_take),
        .busy      (gap_busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cke_prev_q  <= 1'b1;
            cmd_q       <= CMD_DESEL;
            bank_o      <= '0;
            addr_o      <= '0;
            auto_pre_o  <= 1'b0;
            all_banks_o <= 1'b0;
            err_o       <= 1'b0;
        end else begin
            cke_prev_q  <= cke;
            err_o       <= err_o | reject;
            bank_o      <= '0;
            addr_o      <= '0;
            auto_pre_o  <= 1'b0;
            all_banks_o <= 1'b0;
            if (reject) begin
                cmd_q <= CMD_NOP;
            end else begin
                cmd_q <= raw_cmd;
                unique case (raw_cmd)
                    CMD_ACT: begin
                        bank_o <= ba;
                        addr_o <= a;
                    end
                    CMD_RD, CMD_WR: begin
                        bank_o     <= ba;
                        addr_o     <= ROW_W'(a[COL_W-1:0]);
                        auto_pre_o <= a[AP_BIT];
                    end
                    CMD_PRE: begin
                        bank_o      <= ba;
                        all_banks_o <= a[AP_BIT];
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    always_comb begin
        cmd_o       = cmd_q;
        cas_lat_o   = mode.cl;
        burst_len_o = mode.bl;
        burst_il_o  = mode.il;
        wr_single_o = mode.wr_single;
        wr_len_o    = mode.wr_single ? 3'd0 : mode.bl;
    end

    assert_mode_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != CMD_MRS) |-> $stable({cas_lat_o, burst_len_o, burst_il_o, wr_single_o}))
        else $error("mode changed without a mode set");

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o)
        else $error("error flag cleared");

    assert_reject_nop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> (cmd_o == CMD_NOP))
        else $error("refused cycle not shown as no-operation");

    assert_ap_only_rw_R4: assert property (@(posedge clk) disable iff (!rst_n)
        auto_pre_o |-> ((cmd_o == CMD_RD) || (cmd_o == CMD_WR)))
        else $error("auto-precharge outside read or write");

    assert_all_only_pre_R5: assert property (@(posedge clk) disable iff (!rst_n)
        all_banks_o |-> (cmd_o == CMD_PRE))
        else $error("all-banks flag outside precharge");

    assert_wr_len_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_single_o |-> (wr_len_o == 3'd0))
        else $error("single write with burst write length");

    generate
        if (MRD_CYCLES > 1) begin : g_gap_chk
            assert_gap_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd_o == CMD_MRS) |=> ((cmd_o == CMD_NOP) || (cmd_o == CMD_DESEL)))
                else $error("command issued in mode-set gap");
        end
    endgenerate

endmodule

// File: tb/sdcmd_frontend_tb.sv
module sdcmd_frontend_tb;

    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] P_MRS = 3'b000;
    localparam logic [2:0] P_NOP = 3'b111;
    localparam logic [2:0] P_ACT = 3'b011;
    localparam logic [2:0] P_RD  = 3'b101;
    localparam logic [2:0] P_WR  = 3'b100;
    localparam logic [2:0] P_PRE = 3'b010;
    localparam logic [2:0] P_BST = 3'b110;
    localparam logic [2:0] P_REF = 3'b001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b0;
    logic        ras_n = 1'b1;
    logic        cas_n = 1'b1;
    logic        we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [11:0] a = '0;
    logic [3:0]  cmd_o;
    logic [1:0]  bank_o;
    logic [11:0] addr_o;
    logic        auto_pre_o;
    logic        all_banks_o;
    logic [1:0]  cas_lat_o;
    logic [2:0]  burst_len_o;
    logic        burst_il_o;
    logic        wr_single_o;
    logic [2:0]  wr_len_o;
    logic        err_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdcmd_frontend u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .a(a), .cmd_o(cmd_o),
        .bank_o(bank_o), .addr_o(addr_o), .auto_pre_o(auto_pre_o),
        .all_banks_o(all_banks_o), .cas_lat_o(cas_lat_o),
        .burst_len_o(burst_len_o), .burst_il_o(burst_il_o),
        .wr_single_o(wr_single_o), .wr_len_o(wr_len_o), .err_o(err_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic c_cs, input logic [2:0] rcw, input logic c_cke,
                         input logic [1:0] c_ba, input logic [11:0] c_a);
        @(negedge clk);
        cs_n = c_cs;
        {ras_n, cas_n, we_n} = rcw;
        cke = c_cke;
        ba = c_ba;
        a = c_a;
        @(posedge clk);
        #1;
    endtask

    task automatic nop();
        issue(1'b0, P_NOP, 1'b1, 2'd0, 12'h000);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cs_n = 1'b0; {ras_n, cas_n, we_n} = P_NOP; cke = 1'b1; ba = '0; a = '0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1 cmd", cmd_o, 0);
        check("R1 cas_lat", cas_lat_o, 3);
        check("R1 burst_len", burst_len_o, 0);
        check("R1 burst_il", burst_il_o, 0);
        check("R1 wr_single", wr_single_o, 0);
        check("R1 wr_len", wr_len_o, 0);
        check("R1 err", err_o, 0);
    endtask

    task automatic t_command_table();
        do_reset();
        nop();                               check("R2 nop", cmd_o, 1);
        issue(1'b0, P_ACT, 1'b1, 2'd0, 12'h001); check("R2 act", cmd_o, 3);
        issue(1'b0, P_RD,  1'b1, 2'd0, 12'h001); check("R2 read", cmd_o, 4);
        issue(1'b0, P_WR,  1'b1, 2'd0, 12'h001); check("R2 write", cmd_o, 5);
        issue(1'b0, P_PRE, 1'b1, 2'd0, 12'h000); check("R2 precharge", cmd_o, 6);
        issue(1'b0, P_BST, 1'b1, 2'd0, 12'h000); check("R2 burst stop", cmd_o, 7);
        issue(1'b0, P_REF, 1'b1, 2'd0, 12'h000); check("R6 auto refresh", cmd_o, 8);
        issue(1'b1, P_MRS, 1'b1, 2'd0, 12'h022); check("R3 deselect", cmd_o, 0);
        check("R3 mode kept cl", cas_lat_o, 3);
        check("R3 mode kept bl", burst_len_o, 0);
        issue(1'b1, P_ACT, 1'b1, 2'd1, 12'h123); check("R3 deselect act", cmd_o, 0);
        check("R2 no error", err_o, 0);
    endtask

    task automatic t_addressing();
        do_reset();
        issue(1'b0, P_ACT, 1'b1, 2'd2, 12'hABC);
        check("R4 act bank", bank_o, 2);
        check("R4 act row", addr_o, 12'hABC);
        check("R4 act ap", auto_pre_o, 0);
        issue(1'b0, P_RD, 1'b1, 2'd3, 12'hFFF);
        check("R4 rd bank", bank_o, 3);
        check("R4 rd col", addr_o, 12'h1FF);
        check("R4 rd ap", auto_pre_o, 1);
        issue(1'b0, P_WR, 1'b1, 2'd1, 12'h0A5);
        check("R4 wr col", addr_o, 12'h0A5);
        check("R4 wr ap", auto_pre_o, 0);
        issue(1'b0, P_PRE, 1'b1, 2'd2, 12'h400);
        check("R5 pre all", all_banks_o, 1);
        check("R4 pre addr", addr_o, 0);
        check("R5 pre ap", auto_pre_o, 0);
        issue(1'b0, P_PRE, 1'b1, 2'd1, 12'h3FF);
        check("R5 pre single", all_banks_o, 0);
        check("R5 pre bank", bank_o, 1);
        issue(1'b0, P_BST, 1'b1, 2'd3, 12'hFFF);
        check("R4 bst addr", addr_o, 0);
        check("R5 bst all", all_banks_o, 0);
    endtask

    task automatic t_refresh();
        do_reset();
        nop();
        issue(1'b0, P_REF, 1'b0, 2'd0, 12'h000); check("R6 self refresh", cmd_o, 9);
        issue(1'b0, P_ACT, 1'b0, 2'd0, 12'h010); check("R6 cke low held", cmd_o, 1);
        issue(1'b0, P_ACT, 1'b1, 2'd0, 12'h010); check("R6 cke rising", cmd_o, 1);
        issue(1'b0, P_ACT, 1'b1, 2'd0, 12'h010); check("R6 resumed", cmd_o, 3);
        issue(1'b0, P_REF, 1'b1, 2'd0, 12'h000); check("R6 auto again", cmd_o, 8);
    endtask

    task automatic t_mode_load();
        do_reset();
        issue(1'b0, P_MRS, 1'b1, 2'd0, 12'h22B);
        check("R7 mrs cmd", cmd_o, 2);
        check("R7 cl2", cas_lat_o, 2);
        check("R7 bl8", burst_len_o, 3);
        check("R7 interleave", burst_il_o, 1);
        check("R7 single", wr_single_o, 1);
        check("R12 single len", wr_len_o, 0);
        nop();
        nop();
        issue(1'b0, P_MRS, 1'b1, 2'd0, 12'h037);
        check("R7 cl3", cas_lat_o, 3);
        check("R7 full page", burst_len_o, 7);
        check("R7 sequential", burst_il_o, 0);
        check("R7 burst write", wr_single_o, 0);
        check("R12 burst len", wr_len_o, 7);
        check("R7 no error", err_o, 0);
    endtask

    task automatic t_reserved_cl();
        do_reset();
        issue(1'b0, P_MRS, 1'b1, 2'd0, 12'h012);
        check("R8 refused cmd", cmd_o, 1);
        check("R8 err", err_o, 1);
        check("R8 cl kept", cas_lat_o, 3);
        check("R8 bl kept", burst_len_o, 0);
        issue(1'b0, P_ACT, 1'b1, 2'd1, 12'h055);
        check("R8 no gap", cmd_o, 3);
        check("R11 sticky", err_o, 1);
        do_reset();
        issue(1'b0, P_MRS, 1'b1, 2'd0, 12'h042);
        check("R8 cl100 refused", err_o, 1);
        check("R8 cl100 kept", cas_lat_o, 3);
    endtask

    task automatic t_reserved_bl();
        do_reset();
        issue(1'b0, P_MRS, 1'b1, 2'd0, 12'h025);
        check("R9 bl101 cmd", cmd_o, 1);
        check("R9 bl101 err", err_o, 1);
        check("R9 bl kept", burst_len_o, 0);
        check("R9 cl kept", cas_lat_o, 3);
        do_reset();
        issue(1'b0, P_MRS, 1'b1, 2'd0, 12'h02F);
        check("R9 full il err", err_o, 1);
        check("R9 il kept", burst_il_o, 0);
        check("R9 full bl kept", burst_len_o, 0);
        do_reset();
        issue(1'b0, P_MRS, 1'b1, 2'd0, 12'h02A);
        check("R9 bl4 il ok", err_o, 0);
        check("R9 bl4 il load", burst_il_o, 1);
    endtask

    task automatic t_gap();
        do_reset();
        issue(1'b0, P_MRS, 1'b1, 2'd0, 12'h020);
        check("R10 mrs taken", cmd_o, 2);
        issue(1'b0, P_RD, 1'b1, 2'd0, 12'h004);
        check("R10 in gap cmd", cmd_o, 1);
        check("R10 in gap err", err_o, 1);
        issue(1'b0, P_RD, 1'b1, 2'd0, 12'h004);
        check("R10 after gap", cmd_o, 4);
        check("R10 after gap addr", addr_o, 4);
        check("R11 still set", err_o, 1);
        do_reset();
        issue(1'b0, P_MRS, 1'b1, 2'd0, 12'h030);
        issue(1'b0, P_MRS, 1'b1, 2'd0, 12'h022);
        check("R10 mrs in gap cmd", cmd_o, 1);
        check("R10 mrs in gap cl", cas_lat_o, 3);
        check("R10 mrs in gap bl", burst_len_o, 0);
        check("R10 mrs in gap err", err_o, 1);
        do_reset();
        issue(1'b0, P_MRS, 1'b1, 2'd0, 12'h020);
        nop();
        check("R10 nop in gap ok", err_o, 0);
        issue(1'b0, P_ACT, 1'b1, 2'd0, 12'h001);
        check("R10 act after nop", cmd_o, 3);
        check("R10 clean", err_o, 0);
    endtask

    task automatic t_sticky();
        do_reset();
        issue(1'b0, P_MRS, 1'b1, 2'd0, 12'h007);
        check("R11 set", err_o, 1);
        for (int i = 0; i < 5; i++) nop();
        issue(1'b0, P_MRS, 1'b1, 2'd0, 12'h020);
        nop();
        check("R11 held", err_o, 1);
        do_reset();
        check("R11 reset clears", err_o, 0);
    endtask

    initial begin
        t_reset_state();
        t_command_table();
        t_addressing();
        t_refresh();
        t_mode_load();
        t_reserved_cl();
        t_reserved_bl();
        t_gap();
        t_sticky();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule